// File: doc/BRIEF.md
# Stop-Mode Entry and Exit Sequencer

This block takes the chip from its run state into one of three stop modes and brings it back. A mode controller raises `start_i` with a two-bit target mode. The block gates the CPU clock at once. It then asks every non-CPU bus master to quiesce, then every bus slave. Only after that does it gate the system clock and, depending on the mode, the bus clock. In the very-low-power mode it also switches off the clock generators and moves the regulator to low-power regulation.

A wake event or a reset undoes this in the reverse order. If the wake arrives while the handshake is still running, entry is abandoned and the clocks are restored in exit order. Request lines stay asserted until the final exit step, so dropping them tells masters and slaves that they may resume. A master or slave that never answers within `ACK_TMO` cycles of a handshake phase causes a stop-acknowledge reset request. Wake inputs are levels that their sources hold until the interrupt is serviced.

The controller states are:
- RUN: idle.
- MREQ: masters are requested.
- SREQ: slaves are requested.
- GATE: system and bus clocks are gated.
- LPREG: the regulator moves to low power.
- STOPPED: the chip is stopped.
- XREG: the regulator and generators are restored.
- XCLK: system and bus clocks are restored.
- XCPU: the CPU clock is restored and requests are released.
- ACKRST: the stop-acknowledge reset is raised.

The transitions are:
- RUN→MREQ on start.
- MREQ→SREQ when all masters have acknowledged.
- SREQ→GATE when all slaves have acknowledged.
- MREQ or SREQ→XCLK on wake (abort).
- MREQ or SREQ→ACKRST on timeout.
- GATE→LPREG in very-low-power mode, and GATE→STOPPED otherwise.
- LPREG→STOPPED.
- STOPPED→XREG in very-low-power mode on wake, and STOPPED→XCLK otherwise.
- XREG→XCLK, then XCLK→XCPU, then XCPU→RUN.
- ACKRST→RUN.

Top module: `lp_stop_seq`

## Requirements
- R1: In RUN, `start_i` high drives `cpu_clk_en_o` low in the same cycle, before any request line rises. `start_i` has no effect in any other state, and the mode captured at entry stays in force.
- R2: Entry first raises every `mst_req_o` bit with `slv_req_o` all low. `slv_req_o` rises on the clock edge after the one where every `mst_ack_i` bit is high. A partial set of master acknowledges leaves the slaves unrequested.
- R3: Mode encoding on `mode_i`: 2'b01 selects STOP1, 2'b10 selects STOP2, 2'b11 selects very-low-power stop (VLPS), and 2'b00 is treated as STOP1. `sys_clk_en_o` falls on the edge after the one where every `slv_ack_i` bit is high, and not before. At that point `bus_clk_en_o` falls too, except in STOP2, where it stays high.
- R4: In VLPS, `gen_en_o` falls together with the system clock unless `keep_gen_i` was high at start. `reg_lp_o` rises one cycle later. In STOP1 and STOP2, `gen_en_o` stays high and `reg_lp_o` stays low.
- R5: `entry_done_o` is high exactly while the block is stopped, which is the cycle after gating (STOP1/STOP2) or after the regulator step (VLPS).
- R6: A wake while stopped first restores the regulator and generators, for one cycle, in VLPS only. The next cycle restores the system and bus clocks with the CPU clock still off and requests still held. The cycle after that raises `cpu_clk_en_o`, drops all request lines and pulses `exit_done_o` for one cycle.
- R7: `wake_async_i` wakes in every mode. `wake_bus_i` wakes only in STOP2 and is ignored in STOP1 and VLPS.
- R8: If a handshake phase (masters, or slaves) lasts `ACK_TMO` cycles without full acknowledge, `ack_rst_o` pulses for one cycle. In that cycle all requests are low and all clocks are enabled, and the block then returns to RUN. The count restarts when the slave phase begins.
- R9: A qualifying wake during the master or slave phase aborts entry: the regulator and generators are never touched and the system clock never gates. Requests stay held for one cycle, then drop as the CPU clock returns and `exit_done_o` pulses.
- R10: `rst_n` low asynchronously returns the block to RUN: all clocks and generators enabled, run regulation, and all request and status outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Stop request from the mode controller |
| mode_i | input | 2 | Target stop mode, sampled with start |
| keep_gen_i | input | 1 | Keep clock generators on in VLPS, sampled with start |
| wake_async_i | input | 1 | Asynchronous wake interrupt, level |
| wake_bus_i | input | 1 | Wake from a bus-clocked slave, level, STOP2 only |
| mst_req_o | output | N_MST | Stop request per bus master |
| mst_ack_i | input | N_MST | Stop acknowledge per bus master |
| slv_req_o | output | N_SLV | Stop request per bus slave |
| slv_ack_i | input | N_SLV | Stop acknowledge per bus slave |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| gen_en_o | output | 1 | Clock generator enable |
| reg_lp_o | output | 1 | Regulator in low-power regulation |
| entry_done_o | output | 1 | Stop entry complete |
| exit_done_o | output | 1 | One-cycle pulse when exit completes |
| ack_rst_o | output | 1 | One-cycle stop-acknowledge reset request |

## Verification
The assertions check several orderings on every cycle:
- The CPU clock is always off before the system clock gates.
- Slaves are never requested unless every master acknowledged on the previous edge.
- The system clock never gates without full slave acknowledge.
- The regulator is never in low power while any clock runs.
- The CPU clock only returns after the system clock and run regulation.

The bench sweeps every mode encoding with both generator settings and applies master and slave acknowledges one bit at a time. It also covers aborts in both handshake phases, timeouts in both phases, wakes from the wrong source, a start issued while stopped, and a reset while stopped. Only these scenarios can show the exact cycle counts of the exit sequence and of the timeout, and the mode-dependent levels of the bus clock and generators.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

    typedef enum logic [1:0] {
        MD_STOP1 = 2'b01,
        MD_STOP2 = 2'b10,
        MD_VLPS  = 2'b11
    } stop_md_e;

    typedef enum logic [3:0] {
        S_RUN,
        S_MREQ,
        S_SREQ,
        S_GATE,
        S_LPREG,
        S_STOPPED,
        S_XREG,
        S_XCLK,
        S_XCPU,
        S_ACKRST
    } seq_st_e;

    function automatic stop_md_e decode_md(input logic [1:0] raw);
        unique case (raw)
            2'b10:   return MD_STOP2;
            2'b11:   return MD_VLPS;
            default: return MD_STOP1;
        endcase
    endfunction

endpackage

// File: rtl/lp_ack_all.sv
module lp_ack_all #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] ack_i,
    output logic             all_o
);
    logic [WIDTH:0] chain;

    assign chain[0] = 1'b1;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_and
            assign chain[i+1] = chain[i] & ack_i[i];
        end
    endgenerate

    assign all_o = chain[WIDTH];
endmodule

// File: rtl/lp_ack_timer.sv
module lp_ack_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = en_i && !clr_i && (cnt_q == LAST);

    // R8
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/lp_wake_qual.sv
module lp_wake_qual (
    input  logic wake_async_i,
    input  logic wake_bus_i,
    input  logic is_stop2_i,
    output logic hit_o
);
    assign hit_o = wake_async_i | (wake_bus_i & is_stop2_i);
endmodule

// File: rtl/lp_stop_seq.sv
module lp_stop_seq
    import lp_seq_pkg::*;
#(
    parameter int N_MST   = 2,
    parameter int N_SLV   = 3,
    parameter int ACK_TMO = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             keep_gen_i,
    input  logic             wake_async_i,
    input  logic             wake_bus_i,
    output logic [N_MST-1:0] mst_req_o,
    input  logic [N_MST-1:0] mst_ack_i,
    output logic [N_SLV-1:0] slv_req_o,
    input  logic [N_SLV-1:0] slv_ack_i,
    output logic             cpu_clk_en_o,
    output logic             sys_clk_en_o,
    output logic             bus_clk_en_o,
    output logic             gen_en_o,
    output logic             reg_lp_o,
    output logic             entry_done_o,
    output logic             exit_done_o,
    output logic             ack_rst_o
);

    seq_st_e  state_q, state_d;
    stop_md_e mode_q;
    logic     keep_q;
    logic     slv_asked_q;

    logic mst_all, slv_all, wake_hit, tmo_hit;
    logic in_phase, phase_adv;
    logic is_vlps, is_stop2;
    logic bus_hold, gen_hold;

    assign is_vlps  = (mode_q == MD_VLPS);
    assign is_stop2 = (mode_q == MD_STOP2);
    assign bus_hold = is_stop2;
    assign gen_hold = !(is_vlps && !keep_q);

    lp_ack_all #(.WIDTH(N_MST)) u_mst_all (.ack_i(mst_ack_i), .all_o(mst_all));
    lp_ack_all #(.WIDTH(N_SLV)) u_slv_all (.ack_i(slv_ack_i), .all_o(slv_all));

    lp_wake_qual u_wake (
        .wake_async_i (wake_async_i),
        .wake_bus_i   (wake_bus_i),
        .is_stop2_i   (is_stop2),
        .hit_o        (wake_hit)
    );

    assign in_phase  = (state_q == S_MREQ) || (state_q == S_SREQ);
    assign phase_adv = (state_q == S_MREQ) && mst_all && !wake_hit;

    lp_ack_timer #(.LIMIT(ACK_TMO)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (in_phase),
        .clr_i     (phase_adv),
        .expired_o (tmo_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:     if (start_i) state_d = S_MREQ;
            S_MREQ: begin
                if (wake_hit)     state_d = S_XCLK;
                else if (mst_all) state_d = S_SREQ;
                else if (tmo_hit) state_d = S_ACKRST;
            end
            S_SREQ: begin
                if (wake_hit)     state_d = S_XCLK;
                else if (slv_all) state_d = S_GATE;
                else if (tmo_hit) state_d = S_ACKRST;
            end
            S_GATE:    state_d = is_vlps ? S_LPREG : S_STOPPED;
            S_LPREG:   state_d = S_STOPPED;
            S_STOPPED: if (wake_hit) state_d = is_vlps ? S_XREG : S_XCLK;
            S_XREG:    state_d = S_XCLK;
            S_XCLK:    state_d = S_XCPU;
            S_XCPU:    state_d = S_RUN;
            S_ACKRST:  state_d = S_RUN;
            default:   state_d = S_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_RUN;
            mode_q      <= MD_STOP1;
            keep_q      <= 1'b0;
            slv_asked_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_RUN && start_i) begin
                mode_q <= decode_md(mode_i);
                keep_q <= keep_gen_i;
            end
            if (state_d == S_SREQ)
                slv_asked_q <= 1'b1;
            else if (state_d == S_RUN || state_d == S_XCPU || state_d == S_ACKRST)
                slv_asked_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        cpu_clk_en_o = 1'b0;
        sys_clk_en_o = 1'b1;
        bus_clk_en_o = 1'b1;
        gen_en_o     = 1'b1;
        reg_lp_o     = 1'b0;
        mst_req_o    = '0;
        slv_req_o    = '0;
        entry_done_o = 1'b0;
        exit_done_o  = 1'b0;
        ack_rst_o    = 1'b0;
        unique case (state_q)
            S_RUN: begin
                cpu_clk_en_o = !start_i;
            end
            S_MREQ: begin
                mst_req_o = '1;
            end
            S_SREQ: begin
                mst_req_o = '1;
                slv_req_o = '1;
            end
            S_GATE: begin
                mst_req_o    = '1;
                slv_req_o    = '1;
                sys_clk_en_o = 1'b0;
                bus_clk_en_o = bus_hold;
                gen_en_o     = gen_hold;
            end
            S_LPREG: begin
                mst_req_o    = '1;
                slv_req_o    = '1;
                sys_clk_en_o = 1'b0;
                bus_clk_en_o = bus_hold;
                gen_en_o     = gen_hold;
                reg_lp_o     = 1'b1;
            end
            S_STOPPED: begin
                mst_req_o    = '1;
                slv_req_o    = '1;
                sys_clk_en_o = 1'b0;
                bus_clk_en_o = bus_hold;
                gen_en_o     = gen_hold;
                reg_lp_o     = is_vlps;
                entry_done_o = 1'b1;
            end
            S_XREG: begin
                mst_req_o    = '1;
                slv_req_o    = '1;
                sys_clk_en_o = 1'b0;
                bus_clk_en_o = bus_hold;
            end
            S_XCLK: begin
                mst_req_o = '1;
                slv_req_o = {N_SLV{slv_asked_q}};
            end
            S_XCPU: begin
                cpu_clk_en_o = 1'b1;
                exit_done_o  = 1'b1;
            end
            S_ACKRST: begin
                cpu_clk_en_o = 1'b1;
                ack_rst_o    = 1'b1;
            end
            default: begin
                cpu_clk_en_o = 1'b1;
            end
        endcase
    end

    // R1
    cpu_before_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_clk_en_o) |-> !cpu_clk_en_o);

    // R2
    slv_after_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_req_o[0]) |-> $past(&mst_ack_i));

    // R3
    sys_gate_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_clk_en_o) |-> $past(&slv_ack_i));

    // R4
    reg_lp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_lp_o |-> (!sys_clk_en_o && !cpu_clk_en_o));

    // R6
    cpu_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en_o) |-> (sys_clk_en_o && !reg_lp_o && gen_en_o));

    // R8
    tmo_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_rst_o) |-> $past(mst_req_o != '0));

    // R5
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(entry_done_o && exit_done_o));

endmodule

// File: tb/lp_stop_seq_test.sv
module lp_stop_seq_test;

    localparam int NM  = 2;
    localparam int NS  = 2;
    localparam int TMO = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic [1:0]    mode_i;
    logic          keep_gen_i;
    logic          wake_async_i;
    logic          wake_bus_i;
    logic [NM-1:0] mst_req_o;
    logic [NM-1:0] mst_ack_i;
    logic [NS-1:0] slv_req_o;
    logic [NS-1:0] slv_ack_i;
    logic cpu_clk_en_o, sys_clk_en_o, bus_clk_en_o, gen_en_o, reg_lp_o;
    logic entry_done_o, exit_done_o, ack_rst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lp_stop_seq #(.N_MST(NM), .N_SLV(NS), .ACK_TMO(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .keep_gen_i(keep_gen_i), .wake_async_i(wake_async_i), .wake_bus_i(wake_bus_i),
        .mst_req_o(mst_req_o), .mst_ack_i(mst_ack_i),
        .slv_req_o(slv_req_o), .slv_ack_i(slv_ack_i),
        .cpu_clk_en_o(cpu_clk_en_o), .sys_clk_en_o(sys_clk_en_o),
        .bus_clk_en_o(bus_clk_en_o), .gen_en_o(gen_en_o), .reg_lp_o(reg_lp_o),
        .entry_done_o(entry_done_o), .exit_done_o(exit_done_o), .ack_rst_o(ack_rst_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int clkvec();
        return {cpu_clk_en_o, sys_clk_en_o, bus_clk_en_o, gen_en_o, reg_lp_o};
    endfunction

    task automatic run_stop(input logic [1:0] md, input logic kp);
        int  eff;
        bit  vl, s2;
        eff = (md == 2'b00) ? 1 : int'(md);
        vl  = (eff == 3);
        s2  = (eff == 2);
        @(negedge clk);
        start_i = 1'b1; mode_i = md; keep_gen_i = kp;
        #1 chk("R1 cpu gated same cycle", cpu_clk_en_o, 0);
        chk("R1 no request yet", int'(mst_req_o), 0);
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 masters first", int'(mst_req_o), (1 << NM) - 1);
        chk("R2 slaves idle", int'(slv_req_o), 0);
        for (int i = 0; i < NM; i++) begin
            mst_ack_i[i] = 1'b1;
            @(negedge clk);
            if (i < NM - 1) chk("R2 partial master ack", int'(slv_req_o), 0);
            else            chk("R2 slaves after masters", int'(slv_req_o), (1 << NS) - 1);
        end
        for (int i = 0; i < NS; i++) begin
            slv_ack_i[i] = 1'b1;
            @(negedge clk);
            if (i < NS - 1) begin
                chk("R3 sys held on partial ack", sys_clk_en_o, 1);
            end else begin
                chk("R3 sys gated", sys_clk_en_o, 0);
                chk("R3 bus per mode", bus_clk_en_o, int'(s2));
                chk("R4 generators", gen_en_o, int'(!(vl && !kp)));
                chk("R4 regulator waits", reg_lp_o, 0);
            end
        end
        if (vl) begin
            @(negedge clk);
            chk("R4 regulator low power", reg_lp_o, 1);
            chk("R5 not done during regulator step", entry_done_o, 0);
        end
        @(negedge clk);
        chk("R5 entry done", entry_done_o, 1);
        chk("R4 regulator level stopped", reg_lp_o, int'(vl));
        // start ignored while stopped
        start_i = 1'b1; mode_i = 2'b01;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 start ignored when stopped", {entry_done_o, sys_clk_en_o, cpu_clk_en_o}, 3'b100);
        if (!s2) begin
            wake_bus_i = 1'b1;
            @(negedge clk);
            wake_bus_i = 1'b0;
            chk("R7 bus wake ignored", entry_done_o, 1);
        end
        if (s2) wake_bus_i = 1'b1; else wake_async_i = 1'b1;
        @(negedge clk);
        wake_bus_i = 1'b0; wake_async_i = 1'b0;
        if (vl) begin
            chk("R6 regulator restored first", clkvec(), 5'b00010);
            @(negedge clk);
        end
        chk("R6 sys/bus restored", clkvec(), 5'b01110);
        chk("R6 requests held", int'(mst_req_o), (1 << NM) - 1);
        @(negedge clk);
        chk("R6 cpu restored", cpu_clk_en_o, 1);
        chk("R6 exit pulse", exit_done_o, 1);
        chk("R6 requests released", int'({mst_req_o, slv_req_o}), 0);
        mst_ack_i = '0; slv_ack_i = '0;
        @(negedge clk);
        chk("R6 exit pulse one cycle", exit_done_o, 0);
        chk("R5 done cleared", entry_done_o, 0);
    endtask

    task automatic run_abort(input bit ph);
        @(negedge clk);
        start_i = 1'b1; mode_i = ph ? 2'b11 : 2'b01; keep_gen_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        if (!ph) begin
            wake_bus_i = 1'b1;
            @(negedge clk);
            wake_bus_i = 1'b0;
            chk("R7 bus wake ignored in handshake", {cpu_clk_en_o, exit_done_o}, 0);
            chk("R7 still requesting", int'(mst_req_o), (1 << NM) - 1);
        end else begin
            mst_ack_i = '1;
            @(negedge clk);
        end
        wake_async_i = 1'b1;
        @(negedge clk);
        wake_async_i = 1'b0;
        chk("R9 abort clocks", clkvec(), 5'b01110);
        chk("R9 masters held", int'(mst_req_o), (1 << NM) - 1);
        chk("R9 slaves held", int'(slv_req_o), ph ? (1 << NS) - 1 : 0);
        @(negedge clk);
        chk("R9 cpu back", cpu_clk_en_o, 1);
        chk("R9 exit pulse", exit_done_o, 1);
        chk("R9 released", int'({mst_req_o, slv_req_o}), 0);
        mst_ack_i = '0;
        @(negedge clk);
    endtask

    task automatic run_tmo(input bit ph);
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'b10;
        @(negedge clk);
        start_i = 1'b0;
        if (ph) begin
            mst_ack_i = '1;
            @(negedge clk);
        end
        for (int i = 1; i <= TMO; i++) begin
            @(negedge clk);
            if (i == TMO - 1) chk("R8 no early timeout", ack_rst_o, 0);
        end
        chk("R8 timeout pulse", ack_rst_o, 1);
        chk("R8 requests dropped", int'({mst_req_o, slv_req_o}), 0);
        chk("R8 clocks on", clkvec(), 5'b11110);
        @(negedge clk);
        chk("R8 back to run", {ack_rst_o, cpu_clk_en_o}, 2'b01);
        mst_ack_i = '0;
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; mode_i = 2'b00; keep_gen_i = 1'b0;
        wake_async_i = 1'b0; wake_bus_i = 1'b0; mst_ack_i = '0; slv_ack_i = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset clocks", clkvec(), 5'b11110);
        chk("R10 reset status", int'({mst_req_o, slv_req_o, entry_done_o, exit_done_o, ack_rst_o}), 0);
        rst_n = 1'b1;
        for (int md = 0; md < 4; md++)
            for (int kp = 0; kp < 2; kp++)
                run_stop(2'(md), 1'(kp));
        run_abort(1'b0);
        run_abort(1'b1);
        run_tmo(1'b0);
        run_tmo(1'b1);
        // reset while stopped in VLPS
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'b11;
        @(negedge clk);
        start_i = 1'b0; mst_ack_i = '1;
        @(negedge clk);
        slv_ack_i = '1;
        repeat (3) @(negedge clk);
        chk("R5 stopped before reset", entry_done_o, 1);
        rst_n = 1'b0;
        #1 chk("R10 async reset clocks", clkvec(), 5'b11110);
        chk("R10 async reset status", int'({mst_req_o, slv_req_o, entry_done_o}), 0);
        mst_ack_i = '0; slv_ack_i = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule